// File: doc/BRIEF.md
# Video Sync Source Selector and Polarity Conditioner

This block sits in the sync path of a video capture front end. It receives two horizontal sync candidates: a dedicated Hsync pin and the digital output of a sync-on-green slicer. It also receives two vertical sync candidates: a raw Vsync and a Vsync recovered by a sync separator. It chooses one source of each kind, works out the active level of the chosen horizontal sync, and drives registered output syncs whose polarity software can program.

An 8-bit control word sets the behaviour. It has three override bits. Each one switches one choice (input polarity, Hsync source or Vsync source) between automatic operation and a manual value held in the word. In automatic mode, the Hsync source and the Vsync source follow interface-select status bits supplied by external activity detectors. The input polarity is measured over one line window of `LINE_CYC` clocks: if the sync was high for more than half of the window, it is taken as active low. If both Hsync candidates are flagged active, the manual Hsync choice applies even when its override bit is clear.

Top module: `sync_steer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the control word is 0x40, `hs_out` and `vs_out` are 0, and `hs_pol` reads 1 (active high).
- R2: When control bit 7 is 1, `hs_pol` equals control bit 6. A value of 1 means active high and 0 means active low.
- R3: When control bit 7 is 0, `hs_pol` is the detected polarity. At the end of each window of `LINE_CYC` clocks, the detector sets it to 0 if the selected Hsync was high for more than half of the window. Otherwise, including an exact tie, it sets it to 1.
- R4: One clock after the inputs are sampled, `hs_out` equals the selected Hsync level XOR (NOT `hs_pol`) XOR control bit 5. When bit 5 is 0 the output is active high; when bit 5 is 1 it is active low.
- R5: When control bit 4 is 1, `hs_src` equals control bit 3. A value of 0 selects `hs_pin` and 1 selects `sog_in`.
- R6: When control bit 4 is 0, `hs_src` follows `hs_if_sel`. The exception is when `hs_act` and `sog_act` are both 1; then `hs_src` equals control bit 3.
- R7: When control bit 1 is 1, `vs_src` equals control bit 0; otherwise `vs_src` follows `vs_if_sel`. A value of 0 selects `vs_raw` and 1 selects `vs_sep`.
- R8: One clock after the inputs are sampled, `vs_out` equals the selected Vsync level XOR control bit 2.
- R9: The control word loads `ctrl_wd` on a clock edge where `ctrl_we` is 1. When `ctrl_we` is 0, the value on `ctrl_wd` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write enable |
| ctrl_wd | input | 8 | Control word write data |
| hs_pin | input | 1 | Dedicated horizontal sync input |
| sog_in | input | 1 | Sync-on-green slicer output |
| vs_raw | input | 1 | Raw vertical sync |
| vs_sep | input | 1 | Separator-recovered vertical sync |
| hs_act | input | 1 | Activity flag for `hs_pin` |
| sog_act | input | 1 | Activity flag for `sog_in` |
| hs_if_sel | input | 1 | Automatic Hsync source choice (0 pin, 1 sync-on-green) |
| vs_if_sel | input | 1 | Automatic Vsync source choice (0 raw, 1 separated) |
| hs_out | output | 1 | Registered conditioned horizontal sync |
| vs_out | output | 1 | Registered conditioned vertical sync |
| hs_pol | output | 1 | Effective input Hsync polarity (1 active high) |
| hs_src | output | 1 | Selected Hsync source |
| vs_src | output | 1 | Selected Vsync source |

## Verification
The bench targets the case where both Hsync candidates are active but the override bit is clear. A design that ignored this case would follow the status bit and drive the wrong sync. For the polarity detector, it uses exactly half-high and three-quarter-high line patterns; a design with an off-by-one majority compare would report active low on the tie. It also checks both output inversion bits, since a swapped XOR term would flip one of the syncs. Finally, it presents write data while the enable is low; a register that loads without the enable would change `hs_pol`.

// File: rtl/sync_steer_pkg.sv
package sync_steer_pkg;

    typedef struct packed {
        logic hpol_ovr;   // bit 7
        logic hpol_val;   // bit 6
        logic hout_inv;   // bit 5
        logic hsrc_ovr;   // bit 4
        logic hsrc_man;   // bit 3
        logic vout_inv;   // bit 2
        logic vsrc_ovr;   // bit 1
        logic vsrc_man;   // bit 0
    } ctrl_t;

    localparam logic [7:0] CTRL_RST = 8'h40;

    typedef enum logic { HS_PIN = 1'b0, HS_SOG = 1'b1 } hsrc_e;
    typedef enum logic { VS_RAW = 1'b0, VS_SEP = 1'b1 } vsrc_e;

    function automatic hsrc_e pick_hsrc(ctrl_t c, logic if_sel,
                                        logic act_a, logic act_b);
        if (c.hsrc_ovr || (act_a && act_b))
            return hsrc_e'(c.hsrc_man);
        return hsrc_e'(if_sel);
    endfunction

    function automatic vsrc_e pick_vsrc(ctrl_t c, logic if_sel);
        return c.vsrc_ovr ? vsrc_e'(c.vsrc_man) : vsrc_e'(if_sel);
    endfunction

    // Map a sync of the given active level to active high.
    function automatic logic to_active_high(logic lvl, logic act_high);
        return act_high ? lvl : ~lvl;
    endfunction

    // 1 when high samples strictly exceed half of the window.
    function automatic logic mostly_high(int unsigned highs, int unsigned len);
        return (2 * highs) > len;
    endfunction

endpackage

// File: rtl/sync_pol_detect.sv
module sync_pol_detect
    import sync_steer_pkg::*;
#(
    parameter int unsigned LINE_CYC = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_lvl,
    output logic det_pol
);
    localparam int unsigned CW = $clog2(LINE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(LINE_CYC - 1);

    logic [CW-1:0] cyc;
    logic [CW-1:0] hcnt;
    logic [CW-1:0] hnext;

    assign hnext = hcnt + {{(CW-1){1'b0}}, hs_lvl};

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc     <= '0;
            hcnt    <= '0;
            det_pol <= 1'b1;
        end else if (cyc == LAST) begin
            cyc     <= '0;
            hcnt    <= '0;
            det_pol <= ~mostly_high(int'(hnext), LINE_CYC);
        end else begin
            cyc  <= cyc + 1'b1;
            hcnt <= hnext;
        end
    end
endmodule

// File: rtl/sync_src_mux.sv
module sync_src_mux
    import sync_steer_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  hs_pin,
    input  logic  sog_in,
    input  logic  vs_raw,
    input  logic  vs_sep,
    input  logic  hs_act,
    input  logic  sog_act,
    input  logic  hs_if_sel,
    input  logic  vs_if_sel,
    output hsrc_e hsel,
    output vsrc_e vsel,
    output logic  hs_lvl,
    output logic  vs_lvl
);
    always_comb begin
        hsel   = pick_hsrc(ctrl, hs_if_sel, hs_act, sog_act);
        vsel   = pick_vsrc(ctrl, vs_if_sel);
        hs_lvl = (hsel == HS_SOG) ? sog_in : hs_pin;
        vs_lvl = (vsel == VS_SEP) ? vs_sep : vs_raw;
    end
endmodule

// File: rtl/sync_out_stage.sv
module sync_out_stage
    import sync_steer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  hs_lvl,
    input  logic  vs_lvl,
    input  logic  pol,
    output logic  hs_out,
    output logic  vs_out
);
    logic hs_nxt;
    logic vs_nxt;

    always_comb begin
        hs_nxt = to_active_high(hs_lvl, pol) ^ ctrl.hout_inv;
        vs_nxt = vs_lvl ^ ctrl.vout_inv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_out <= 1'b0;
            vs_out <= 1'b0;
        end else begin
            hs_out <= hs_nxt;
            vs_out <= vs_nxt;
        end
    end
endmodule

// File: rtl/sync_steer.sv
module sync_steer
    import sync_steer_pkg::*;
#(
    parameter int unsigned LINE_CYC = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wd,
    input  logic       hs_pin,
    input  logic       sog_in,
    input  logic       vs_raw,
    input  logic       vs_sep,
    input  logic       hs_act,
    input  logic       sog_act,
    input  logic       hs_if_sel,
    input  logic       vs_if_sel,
    output logic       hs_out,
    output logic       vs_out,
    output logic       hs_pol,
    output logic       hs_src,
    output logic       vs_src
);
    ctrl_t ctrl_q;
    hsrc_e hsel;
    vsrc_e vsel;
    logic  hs_lvl;
    logic  vs_lvl;
    logic  det_pol;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= ctrl_t'(CTRL_RST);
        else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wd);
    end

    sync_src_mux u_mux (
        .ctrl(ctrl_q), .hs_pin(hs_pin), .sog_in(sog_in),
        .vs_raw(vs_raw), .vs_sep(vs_sep), .hs_act(hs_act),
        .sog_act(sog_act), .hs_if_sel(hs_if_sel), .vs_if_sel(vs_if_sel),
        .hsel(hsel), .vsel(vsel), .hs_lvl(hs_lvl), .vs_lvl(vs_lvl)
    );

    sync_pol_detect #(.LINE_CYC(LINE_CYC)) u_det (
        .clk(clk), .rst(rst), .hs_lvl(hs_lvl), .det_pol(det_pol)
    );

    assign hs_pol = ctrl_q.hpol_ovr ? ctrl_q.hpol_val : det_pol;
    assign hs_src = logic'(hsel);
    assign vs_src = logic'(vsel);

    sync_out_stage u_out (
        .clk(clk), .rst(rst), .ctrl(ctrl_q), .hs_lvl(hs_lvl),
        .vs_lvl(vs_lvl), .pol(hs_pol), .hs_out(hs_out), .vs_out(vs_out)
    );
endmodule

// File: rtl/sync_steer_chk.sv
module sync_steer_chk
    import sync_steer_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  ctrl_we,
    input ctrl_t ctrl_q,
    input logic  hs_pin,
    input logic  sog_in,
    input logic  vs_raw,
    input logic  vs_sep,
    input logic  hs_act,
    input logic  sog_act,
    input logic  vs_if_sel,
    input logic  hs_out,
    input logic  vs_out,
    input logic  hs_pol,
    input logic  hs_src,
    input logic  vs_src
);
    logic seen;
    always_ff @(posedge clk) seen <= !rst;

    a_r2_pol_manual: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.hpol_ovr |-> hs_pol == ctrl_q.hpol_val);

    a_r4_hs_path: assert property (@(posedge clk) disable iff (rst)
        seen |-> hs_out == ($past(hs_src ? sog_in : hs_pin)
                            ^ !$past(hs_pol) ^ $past(ctrl_q.hout_inv)));

    a_r5_hs_manual: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.hsrc_ovr |-> hs_src == ctrl_q.hsrc_man);

    a_r6_both_active: assert property (@(posedge clk) disable iff (rst)
        (hs_act && sog_act) |-> hs_src == ctrl_q.hsrc_man);

    a_r7_vs_select: assert property (@(posedge clk) disable iff (rst)
        vs_src == (ctrl_q.vsrc_ovr ? ctrl_q.vsrc_man : vs_if_sel));

    a_r8_vs_path: assert property (@(posedge clk) disable iff (rst)
        seen |-> vs_out == ($past(vs_src ? vs_sep : vs_raw)
                            ^ $past(ctrl_q.vout_inv)));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> $stable(ctrl_q));
endmodule

bind sync_steer sync_steer_chk u_chk (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_q(ctrl_q),
    .hs_pin(hs_pin), .sog_in(sog_in), .vs_raw(vs_raw), .vs_sep(vs_sep),
    .hs_act(hs_act), .sog_act(sog_act), .vs_if_sel(vs_if_sel),
    .hs_out(hs_out), .vs_out(vs_out), .hs_pol(hs_pol),
    .hs_src(hs_src), .vs_src(vs_src)
);

// File: tb/sim_sync_steer.sv
`timescale 1ns/1ps
module sim_sync_steer;
    localparam int unsigned LINE = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctrl_we = 1'b0;
    logic [7:0] ctrl_wd = 8'h00;
    logic hs_pin = 1'b0, sog_in = 1'b0, vs_raw = 1'b0, vs_sep = 1'b0;
    logic hs_act = 1'b0, sog_act = 1'b0, hs_if_sel = 1'b0, vs_if_sel = 1'b0;
    logic hs_out, vs_out, hs_pol, hs_src, vs_src;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sync_steer #(.LINE_CYC(LINE)) u0 (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
        .hs_pin(hs_pin), .sog_in(sog_in), .vs_raw(vs_raw), .vs_sep(vs_sep),
        .hs_act(hs_act), .sog_act(sog_act), .hs_if_sel(hs_if_sel),
        .vs_if_sel(vs_if_sel), .hs_out(hs_out), .vs_out(vs_out),
        .hs_pol(hs_pol), .hs_src(hs_src), .vs_src(vs_src)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1;
        ctrl_wd = v;
        step();
        ctrl_we = 1'b0;
    endtask

    function automatic logic model_hs(logic pin, logic sog, logic src,
                                      logic pol, logic inv);
        logic l = src ? sog : pin;
        return (pol ? l : !l) ^ inv;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check(hs_out, 1'b0, "R1 hs_out in reset");
        check(vs_out, 1'b0, "R1 vs_out in reset");
        check(hs_pol, 1'b1, "R1 hs_pol in reset");
        rst = 1'b0;
        step();
        check(hs_pol, 1'b1, "R1 hs_pol after reset");
        check(hs_out, 1'b0, "R1 hs_out after reset");
    endtask

    task automatic t_pol_override();
        write_ctrl(8'h80);               // override, active low
        check(hs_pol, 1'b0, "R2 manual active low");
        write_ctrl(8'hC0);
        check(hs_pol, 1'b1, "R2 manual active high");
    endtask

    task automatic t_hs_manual();
        hs_pin = 1'b1; sog_in = 1'b0; hs_if_sel = 1'b0;
        for (int i = 0; i < 8; i++) begin
            logic [7:0] c;
            c = 8'h90 | (i[0] ? 8'h08 : 8'h00) | (i[1] ? 8'h40 : 8'h00)
                      | (i[2] ? 8'h20 : 8'h00);
            write_ctrl(c);
            hs_if_sel = !c[3];
            check(hs_src, c[3], "R5 manual hsync source");
            step();
            check(hs_out, model_hs(hs_pin, sog_in, c[3], c[6], c[5]),
                  "R4 hs_out polarity and inversion");
        end
        // one-cycle latency: change input and look before and after the edge
        write_ctrl(8'hD0);               // pin, active high, no invert
        hs_pin = 1'b0;
        step();
        hs_pin = 1'b1;
        #1 check(hs_out, 1'b0, "R4 no change before edge");
        step();
        check(hs_out, 1'b1, "R4 follows after one clock");
    endtask

    task automatic t_hs_auto();
        write_ctrl(8'hC8);               // auto source, manual choice sog
        hs_pin = 1'b0; sog_in = 1'b1;
        hs_act = 1'b1; sog_act = 1'b0; hs_if_sel = 1'b0;
        step();
        check(hs_src, 1'b0, "R6 status picks pin");
        check(hs_out, 1'b0, "R6 pin level on output");
        hs_if_sel = 1'b1;
        step();
        check(hs_src, 1'b1, "R6 status picks sog");
        hs_if_sel = 1'b0; sog_act = 1'b1;
        step();
        check(hs_src, 1'b1, "R6 both active uses manual bit");
        check(hs_out, 1'b1, "R6 both active output from sog");
        hs_act = 1'b0; sog_act = 1'b0;
    endtask

    task automatic t_vs();
        for (int i = 0; i < 8; i++) begin
            logic [7:0] c;
            c = 8'hC0 | (i[0] ? 8'h01 : 8'h00) | (i[1] ? 8'h02 : 8'h00)
                      | (i[2] ? 8'h04 : 8'h00);
            vs_raw = 1'b1; vs_sep = 1'b0; vs_if_sel = !c[0];
            write_ctrl(c);
            begin
                logic s;
                s = c[1] ? c[0] : !c[0];
                check(vs_src, s, "R7 vsync source");
                step();
                check(vs_out, (s ? vs_sep : vs_raw) ^ c[2], "R8 vs_out");
            end
        end
    endtask

    task automatic run_pattern(input int period, input int highs);
        for (int k = 0; k < 3 * LINE; k++) begin
            hs_pin = (k % period) < highs;
            step();
        end
    endtask

    task automatic t_autodetect();
        write_ctrl(8'h00);               // auto polarity, source from status
        hs_if_sel = 1'b0;
        run_pattern(1, 1);               // always high
        check(hs_pol, 1'b0, "R3 mostly high gives active low");
        hs_pin = 1'b1;
        step();
        check(hs_out, 1'b0, "R4 active-low input idle gives 0");
        hs_pin = 1'b0;
        step();
        check(hs_out, 1'b1, "R4 active-low pulse gives 1");
        run_pattern(2, 1);               // exact half
        check(hs_pol, 1'b1, "R3 tie gives active high");
        run_pattern(4, 3);               // three quarters high
        check(hs_pol, 1'b0, "R3 75 percent high gives active low");
        run_pattern(4, 1);
        check(hs_pol, 1'b1, "R3 25 percent high gives active high");
    endtask

    task automatic t_write_ignore();
        write_ctrl(8'h80);
        ctrl_wd = 8'hFF;
        step();
        step();
        check(hs_pol, 1'b0, "R9 data ignored without enable");
        write_ctrl(8'hC0);
        check(hs_pol, 1'b1, "R9 write with enable loads");
    endtask

    initial begin
        t_reset();
        t_pol_override();
        t_hs_manual();
        t_hs_auto();
        t_vs();
        t_autodetect();
        t_write_ignore();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule